// File: doc/BRIEF.md
# Sinc3 Decimation Filter with Selectable Oversampling Ratio

This block turns the output of a five-level delta-sigma modulator into decimated two's-complement words. The modulator output arrives as a four-bit thermometer code, one sample per modulator clock, marked by a sample strobe. Each sample is decoded to a signed level from -2 to +2. Three integrators run at the sample rate. After decimation, three combs run at the output rate.

A two-bit setting selects how many samples make one output word. Each setting has its own resolution. A width bit chooses between two output forms. The 24-bit form is left-justified with zero padding. The 16-bit form is rounded to nearest.

A settle controller tracks the first three words after reset or after a change of setting. These words are not yet settled. When the hold input is high, they are dropped without a strobe.

The controller is a four-state machine:
- `ST_SETTLE0` is entered on reset and on any change of setting.
- It moves to `ST_SETTLE1`, then `ST_SETTLE2`, then `ST_RUN`. Each step happens on the cycle in which the combs produce a word.
- `ST_RUN` stays put until the next change of setting.

Top module: `sinc3_decim`

## Requirements
- R1: A sample is decoded to (number of asserted `therm` bits) − 2. The codes are 0000 = −2, 0001 = −1, 0011 = 0, 0111 = +1 and 1111 = +2.
- R2: The rate code sets the number of accepted samples per word: 00 → 32, 01 → 64, 10 → 128, 11 → 256. Only cycles with `samp_vld` high count as samples.
- R3: Each word is formatted from y. The value y is the sum, over the decoded samples since the last clear, of the sample weighted by the coefficients of (1 + z + … + z^(R−1))³, aligned to the last sample of the frame. Samples before the clear count as zero.
- R4: The resolution N is 17, 20, 23 or 24 bits for rate codes 00, 01, 10 and 11. The value r = y >>> (3·log2(R) + 2 − N) is clipped to N-bit signed. With `wide_sel` = 1, `dout` = r shifted left by 24 − N, so the low 24 − N bits are zero.
- R5: With `wide_sel` = 0, the word is (w + 128) >>> 8, where w is the 24-bit word of R4 (ties round upward). It appears in `dout[15:0]`, and `dout[23:16]` repeats bit 15.
- R6: Positive full scale does not wrap. r clips to 2^(N−1) − 1, and a 16-bit rounding overflow gives 0x7FFF.
- R7: `drdy` is a one-cycle pulse. It rises two rising edges after the edge that captures the last sample of a frame. `dout` holds its value between pulses.
- R8: With `settle_hold` = 1, the first three words after a clear give no `drdy` and leave `dout` unchanged. With `settle_hold` = 0, every word is emitted.
- R9: A change of `osr_sel` or `wide_sel` against the stored setting does four things: it clears all filter state, drops the sample offered in that cycle, drops any partial frame, and restarts the settle count. The stored setting is 00/0 after reset.
- R10: After reset, `dout` is zero and `drdy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_vld | input | 1 | Marks a cycle that carries a modulator sample |
| therm | input | CMP_N (4) | Thermometer-coded modulator level |
| osr_sel | input | 2 | Oversampling ratio code |
| wide_sel | input | 1 | 1: 24-bit padded word, 0: 16-bit rounded word |
| settle_hold | input | 1 | Suppress the three unsettled words after a clear |
| dout | output | OUT_W (24) | Output word |
| drdy | output | 1 | One-cycle data-ready strobe |

## Verification
A word is due exactly two rising edges after the edge that takes the last sample of its frame. One edge updates the integrators and flags the decimation. The second edge runs the combs and registers the formatted word together with `drdy`.

When the driver hands over the final sample of a frame, it computes the expected word with a direct convolution. It queues that word along with its due cycle. The monitor samples at the falling edge and compares both the value and the cycle of every strobe. Between strobes, the monitor checks that `dout` stays where it was. This also covers the words suppressed while settling.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    typedef enum logic [1:0] {
        ST_SETTLE0,
        ST_SETTLE1,
        ST_SETTLE2,
        ST_RUN
    } settle_e;

    localparam int OSR_LG_BASE = 5;

    // log2 of the decimation ratio for a rate code
    function automatic int osr_lg(input logic [1:0] code);
        return OSR_LG_BASE + int'(code);
    endfunction

    // effective resolution in bits for a rate code
    function automatic int res_bits(input logic [1:0] code);
        int n;
        unique case (code)
            2'd0:    n = 17;
            2'd1:    n = 20;
            2'd2:    n = 23;
            default: n = 24;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sinc3_therm_dec.sv
module sinc3_therm_dec #(
    parameter int CMP_N = 4,
    parameter int IN_W  = 3
) (
    input  logic [CMP_N-1:0]        therm,
    output logic signed [IN_W-1:0]  level
);
    int ones;

    always_comb begin
        ones = 0;
        for (int i = 0; i < CMP_N; i++) begin
            ones = ones + int'(therm[i]);
        end
        level = IN_W'(ones - CMP_N / 2);
    end
endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
    parameter int ORDER = 3,
    parameter int IN_W  = 3,
    parameter int ACC_W = 27
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic signed [IN_W-1:0]  din,
    output logic signed [ACC_W-1:0] acc_out
);
    logic signed [ACC_W-1:0] acc_q [ORDER];
    logic signed [ACC_W-1:0] chain [ORDER+1];

    assign chain[0] = ACC_W'(din);

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        assign chain[g+1] = acc_q[g] + chain[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q[g] <= '0;
            end else if (clr) begin
                acc_q[g] <= '0;
            end else if (en) begin
                acc_q[g] <= chain[g+1];
            end
        end
    end

    assign acc_out = acc_q[ORDER-1];
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
    parameter int ORDER = 3,
    parameter int ACC_W = 27
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic signed [ACC_W-1:0] x,
    output logic signed [ACC_W-1:0] y
);
    logic signed [ACC_W-1:0] dly_q [ORDER];
    logic signed [ACC_W-1:0] diff [ORDER+1];

    assign diff[0] = x;

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        assign diff[g+1] = diff[g] - dly_q[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dly_q[g] <= '0;
            end else if (clr) begin
                dly_q[g] <= '0;
            end else if (en) begin
                dly_q[g] <= diff[g];
            end
        end
    end

    assign y = diff[ORDER];
endmodule

// File: rtl/sinc3_fmt.sv
module sinc3_fmt
    import sinc3_pkg::*;
#(
    parameter int ORDER    = 3,
    parameter int IN_W     = 3,
    parameter int ACC_W    = 27,
    parameter int OUT_W    = 24,
    parameter int NARROW_W = 16
) (
    input  logic signed [ACC_W-1:0] y,
    input  logic [1:0]              osr,
    input  logic                    wide,
    output logic [OUT_W-1:0]        word
);
    localparam int DROP_W = OUT_W - NARROW_W;

    int lg;
    int nres;
    int sh;
    logic signed [ACC_W-1:0] r_raw;
    logic signed [ACC_W-1:0] r_hi;
    logic signed [ACC_W-1:0] r_lo;
    logic signed [ACC_W-1:0] r_sat;
    logic signed [OUT_W-1:0] w_full;
    logic signed [OUT_W:0]   t_sum;
    logic signed [OUT_W:0]   t_sh;
    logic signed [OUT_W:0]   t_max;

    always_comb begin
        lg     = osr_lg(osr);
        nres   = res_bits(osr);
        sh     = ORDER * lg + IN_W - 1 - nres;
        r_raw  = y >>> sh;
        r_hi   = ACC_W'((1 <<< (nres - 1)) - 1);
        r_lo   = ~r_hi;
        if (r_raw > r_hi) begin
            r_sat = r_hi;
        end else if (r_raw < r_lo) begin
            r_sat = r_lo;
        end else begin
            r_sat = r_raw;
        end
        w_full = OUT_W'(r_sat <<< (OUT_W - nres));
        t_sum  = (OUT_W+1)'(w_full) + (OUT_W+1)'(1 <<< (DROP_W - 1));
        t_sh   = t_sum >>> DROP_W;
        t_max  = (OUT_W+1)'((1 <<< (NARROW_W - 1)) - 1);
        if (t_sh > t_max) begin
            t_sh = t_max;
        end
        if (wide) begin
            word = w_full;
        end else begin
            word = {{DROP_W{t_sh[NARROW_W-1]}}, t_sh[NARROW_W-1:0]};
        end
    end
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
    import sinc3_pkg::*;
#(
    parameter int CMP_N     = 4,
    parameter int ORDER     = 3,
    parameter int MAX_LOG2R = 8,
    parameter int OUT_W     = 24,
    parameter int NARROW_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_vld,
    input  logic [CMP_N-1:0] therm,
    input  logic [1:0]       osr_sel,
    input  logic             wide_sel,
    input  logic             settle_hold,
    output logic [OUT_W-1:0] dout,
    output logic             drdy
);
    localparam int IN_W  = $clog2(CMP_N / 2 + 1) + 1;
    localparam int ACC_W = IN_W + ORDER * MAX_LOG2R;
    localparam int CNT_W = MAX_LOG2R;

    // stored setting: {rate code, width bit}
    logic [2:0]              cfg_q;
    logic                    cfg_chg;
    logic                    accept;
    logic [CNT_W-1:0]        cnt_q;
    logic [CNT_W-1:0]        last_idx;
    logic                    frame_end;
    logic                    dec_tick_q;
    logic                    emit;
    settle_e                 state_q;
    settle_e                 state_d;
    logic signed [IN_W-1:0]  level;
    logic signed [ACC_W-1:0] integ_y;
    logic signed [ACC_W-1:0] comb_y;
    logic [OUT_W-1:0]        word;
    logic [OUT_W-1:0]        dout_q;
    logic                    drdy_q;
    logic [OUT_W-1:0]        pad_mask;

    assign cfg_chg   = ({osr_sel, wide_sel} != cfg_q);
    assign accept    = samp_vld && !cfg_chg;
    assign last_idx  = CNT_W'((1 << osr_lg(cfg_q[2:1])) - 1);
    assign frame_end = (cnt_q == last_idx);
    assign emit      = dec_tick_q && !cfg_chg && (state_q == ST_RUN || !settle_hold);

    sinc3_therm_dec #(.CMP_N(CMP_N), .IN_W(IN_W)) u_dec (
        .therm (therm),
        .level (level)
    );

    sinc3_integ #(.ORDER(ORDER), .IN_W(IN_W), .ACC_W(ACC_W)) u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cfg_chg),
        .en      (accept),
        .din     (level),
        .acc_out (integ_y)
    );

    sinc3_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_chg),
        .en    (dec_tick_q && !cfg_chg),
        .x     (integ_y),
        .y     (comb_y)
    );

    sinc3_fmt #(
        .ORDER(ORDER), .IN_W(IN_W), .ACC_W(ACC_W),
        .OUT_W(OUT_W), .NARROW_W(NARROW_W)
    ) u_fmt (
        .y    (comb_y),
        .osr  (cfg_q[2:1]),
        .wide (cfg_q[0]),
        .word (word)
    );

    // setting register, sample counter and decimation flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            cnt_q      <= '0;
            dec_tick_q <= 1'b0;
        end else if (cfg_chg) begin
            cfg_q      <= {osr_sel, wide_sel};
            cnt_q      <= '0;
            dec_tick_q <= 1'b0;
        end else begin
            dec_tick_q <= accept && frame_end;
            if (accept) begin
                cnt_q <= frame_end ? '0 : cnt_q + 1'b1;
            end
        end
    end

    // settle state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SETTLE0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (cfg_chg) begin
            state_d = ST_SETTLE0;
        end else if (dec_tick_q) begin
            unique case (state_q)
                ST_SETTLE0: state_d = ST_SETTLE1;
                ST_SETTLE1: state_d = ST_SETTLE2;
                ST_SETTLE2: state_d = ST_RUN;
                ST_RUN:     state_d = ST_RUN;
                default:    state_d = ST_SETTLE0;
            endcase
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drdy_q <= 1'b0;
            dout_q <= '0;
        end else begin
            drdy_q <= emit;
            if (emit) begin
                dout_q <= word;
            end
        end
    end

    assign dout = dout_q;
    assign drdy = drdy_q;
    assign pad_mask = OUT_W'((1 << (OUT_W - res_bits(cfg_q[2:1]))) - 1);

    // R7
    drdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drdy_q |=> !drdy_q);

    // R8
    settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_hold && state_q != ST_RUN) |=> !drdy_q);

    // R9
    cfg_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (!drdy_q && state_q == ST_SETTLE0 && cnt_q == '0));

    // R5
    sext16_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drdy_q && !cfg_q[0]) |->
            (dout_q[OUT_W-1:NARROW_W] == {(OUT_W-NARROW_W){dout_q[NARROW_W-1]}}));

    // R4
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drdy_q && cfg_q[0]) |-> ((dout_q & pad_mask) == '0));
endmodule

// File: tb/sinc3_decim_test.sv
module sinc3_decim_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        samp_vld = 1'b0;
    logic [3:0]  therm = 4'h3;
    logic [1:0]  osr_sel = 2'd0;
    logic        wide_sel = 1'b0;
    logic        settle_hold = 1'b0;
    logic [23:0] dout;
    logic        drdy;

    always #10 clk = ~clk;

    sinc3_decim uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .samp_vld    (samp_vld),
        .therm       (therm),
        .osr_sel     (osr_sel),
        .wide_sel    (wide_sel),
        .settle_hold (settle_hold),
        .dout        (dout),
        .drdy        (drdy)
    );

    int     n_cmp = 0;
    int     n_bad = 0;
    longint cyc = 0;
    bit     mon_on = 0;
    bit     done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // scoreboard
    logic [23:0] exp_q[$];
    longint      due_q[$];
    string       tag_q[$];

    // reference model state
    int    m_osr = 0;
    bit    m_wide = 0;
    int    R = 32;
    int    h[$];
    int    hist[$];
    int    nin = 0;
    int    nout = 0;
    string cur_tag = "R3";

    logic [23:0] last_dout = '0;
    logic        prev_drdy = 1'b0;

    task automatic check(string req, longint act, longint expv, string what);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic build_h();
        int acc[$];
        h.delete();
        for (int i = 0; i < R; i++) h.push_back(1);
        repeat (2) begin
            acc.delete();
            for (int i = 0; i < h.size() + R - 1; i++) acc.push_back(0);
            for (int i = 0; i < h.size(); i++)
                for (int j = 0; j < R; j++) acc[i+j] += h[i];
            h = acc;
        end
    endtask

    function automatic logic [23:0] fmt(longint y, int o, bit w);
        int     lg;
        int     n;
        longint r;
        longint hi;
        longint wv;
        longint t;
        logic [63:0] tb;
        lg = 5 + o;
        n  = (o == 0) ? 17 : (o == 1) ? 20 : (o == 2) ? 23 : 24;
        r  = y >>> (3 * lg + 2 - n);
        hi = (longint'(1) <<< (n - 1)) - 1;
        if (r > hi) r = hi;
        if (r < -hi - 1) r = -hi - 1;
        wv = r <<< (24 - n);
        if (w) begin
            tb = 64'(wv);
            return tb[23:0];
        end
        t = (wv + 128) >>> 8;
        if (t > 32767) t = 32767;
        tb = 64'(t);
        return {{8{tb[15]}}, tb[15:0]};
    endfunction

    task automatic feed(int v);
        longint y;
        @(negedge clk);
        samp_vld = 1'b1;
        therm = 4'((1 << (v + 2)) - 1);
        hist.push_back(v);
        nin++;
        if (nin % R == 0) begin
            y = 0;
            nout++;
            for (int j = 0; j < h.size(); j++) begin
                if (nin - 1 - j >= 0) y += longint'(h[j]) * longint'(hist[nin-1-j]);
            end
            if (!(settle_hold && nout <= 3)) begin
                exp_q.push_back(fmt(y, m_osr, m_wide));
                due_q.push_back(cyc + 2);
                tag_q.push_back(cur_tag);
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            samp_vld = 1'b0;
        end
    endtask

    task automatic set_cfg(int o, bit w, bit with_samp);
        @(negedge clk);
        osr_sel  = 2'(o);
        wide_sel = w;
        samp_vld = with_samp;
        therm    = 4'hF;
        m_osr  = o;
        m_wide = w;
        R      = 1 << (5 + o);
        hist.delete();
        nin  = 0;
        nout = 0;
        build_h();
        @(negedge clk);
        samp_vld = 1'b0;
    endtask

    function automatic int rnd_level();
        return int'($urandom_range(4)) - 2;
    endfunction

    // monitor
    always @(negedge clk) begin
        if (mon_on) begin
            if (drdy) begin
                if (prev_drdy) check("R7", 1, 0, "drdy longer than one cycle");
                if (exp_q.size() == 0) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL R8 unexpected word: actual=0x%0h expected=none", dout);
                end else begin
                    check(tag_q[0], dout, exp_q[0], "word value");
                    check("R7", cyc, due_q[0], "strobe cycle");
                    void'(exp_q.pop_front());
                    void'(due_q.pop_front());
                    void'(tag_q.pop_front());
                end
                last_dout = dout;
            end else begin
                check("R8", dout, last_dout, "dout held between strobes");
            end
            prev_drdy = drdy;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R7 watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        build_h();
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", dout, 0, "dout in reset");
        check("R10", drdy, 0, "drdy in reset");
        rst_n = 1'b1;
        mon_on = 1;
        idle(2);

        // R1/R3/R5: rate 32, 16-bit, all five levels, unsettled words emitted
        cur_tag = "R1/R3/R5";
        for (int i = 0; i < 32 * 10; i++) feed(rnd_level());
        idle(4);

        // R4/R6: 24-bit padded, positive full scale clips, negative full scale exact
        set_cfg(0, 1, 0);
        cur_tag = "R6";
        for (int i = 0; i < 32 * 6; i++) feed(2);
        cur_tag = "R4";
        for (int i = 0; i < 32 * 4; i++) feed(-2);
        idle(4);

        // R2/R8: rate 64 with gaps between samples, hold on
        settle_hold = 1'b1;
        set_cfg(1, 1, 0);
        cur_tag = "R2/R8";
        for (int i = 0; i < 64 * 8; i++) begin
            feed(rnd_level());
            idle(1);
        end
        idle(4);

        // R6: 16-bit rounding overflow saturates, then random words
        settle_hold = 1'b0;
        set_cfg(2, 0, 0);
        cur_tag = "R6";
        for (int i = 0; i < 128 * 5; i++) feed(2);
        cur_tag = "R5";
        for (int i = 0; i < 128 * 4; i++) feed(rnd_level());
        idle(4);

        // R4/R8: rate 256, 24-bit, hold on
        settle_hold = 1'b1;
        set_cfg(3, 1, 0);
        cur_tag = "R4/R8";
        for (int i = 0; i < 256 * 6; i++) feed(rnd_level());

        // R9: partial frame dropped, sample in change cycle dropped
        for (int i = 0; i < 100; i++) feed(2);
        settle_hold = 1'b0;
        set_cfg(1, 0, 1);
        cur_tag = "R9";
        for (int i = 0; i < 64 * 6; i++) feed(rnd_level());
        idle(8);

        check("R7", exp_q.size(), 0, "all expected words delivered");
        summary();
    end
endmodule